// File: doc/BRIEF.md
# Buffered-Limit Pulse Counter

This block counts pulses in the clock domain it is given, which may be a slow sampling clock or a clock taken straight from an external pulse source. A two-bit mode input selects one of four behaviours. In the off mode the block does not count. In the sampled mode it counts edges of a sampled input. In the external single mode every clock edge is one pulse. In the external quadrature mode every clock edge is one pulse and a second input sets the direction. Control inputs choose the counting edge and the counting direction.

The wrap limit is held in a limit register. That register is not written directly. A staging register is written first, and a command then copies it into the limit, so software can prepare a new limit while counting continues. A second command copies the limit into the count. When the count wraps past the limit while counting up, the block raises a one-cycle overflow flag. When the count wraps below zero while counting down, it raises a one-cycle underflow flag. A separate clear input acts at once, without waiting for a clock edge. It forces the count and the limit back to their start values and keeps them there for as long as it is held.

Top module: `edge_tally_core`

## Requirements
- R1: After the synchronous reset `rst`, the count is 0. The limit and the staging register both hold all ones (0xFF at the default width of 8). Both flags are low.
- R2: The `mode` input is encoded as 0 = off, 1 = sampled single input, 2 = external single, 3 = external quadrature. In mode 0, activity on `sig_a` has no effect and the count keeps its value.
- R3: In mode 1, `sig_a` is registered and each new sample is compared with the previous one. Each qualifying edge counts exactly once. A rising edge qualifies when `fall_edge` = 0 and a falling edge qualifies when `fall_edge` = 1. The count changes on the second rising clock edge after the input change.
- R4: In modes 1 and 2, `count_down` = 0 counts up and `count_down` = 1 counts down.
- R5: A pulse counted upward while the count equals the limit sets the count to 0. It also raises `ovf` for exactly one cycle, in the same cycle that the count shows 0.
- R6: A pulse counted downward while the count is 0 loads the count with the limit. It also raises `unf` for exactly one cycle.
- R7: In mode 2, every rising clock edge counts one pulse. `sig_a` and `fall_edge` are ignored.
- R8: In mode 3, every rising clock edge counts one pulse. The direction comes from `sig_b` (0 = up, 1 = down), and `count_down` is ignored.
- R9: Writing the staging register with `buf_wr` leaves the limit unchanged. `cmd_load_top` copies the staging register into the limit on the next clock edge. A staging write in that same cycle is not seen by the copy.
- R10: `cmd_load_cnt` copies the current limit into the count on the next clock edge, and it takes priority over any pulse in that cycle. When `cmd_load_top` is issued in the same cycle, the count receives the old limit.
- R11: While `hold_clr` is high, the count is 0, the limit is all ones and both flags are low. This takes effect at once, without a clock edge. Commands and pulses are ignored until `hold_clr` is released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counting clock (sampling clock or external pulse clock) |
| rst | input | 1 | Synchronous active-high reset |
| hold_clr | input | 1 | Asynchronous clear of count, limit and flags, held while high |
| mode | input | 2 | Operating mode: 0 off, 1 sampled, 2 external single, 3 quadrature |
| fall_edge | input | 1 | Sampled mode counts falling edges when 1, rising edges when 0 |
| count_down | input | 1 | Direction for modes 1 and 2: 1 counts down |
| sig_a | input | 1 | Pulse input used in sampled mode |
| sig_b | input | 1 | Direction input used in quadrature mode: 1 counts down |
| buf_wr | input | 1 | Write strobe for the staging register |
| buf_din | input | W | Data for the staging register |
| cmd_load_top | input | 1 | Command: copy staging register into the limit |
| cmd_load_cnt | input | 1 | Command: copy the limit into the count |
| count | output | W | Current count |
| top | output | W | Current limit |
| ovf | output | 1 | One-cycle flag for an upward wrap to 0 |
| unf | output | 1 | One-cycle flag for a downward wrap to the limit |

## Verification
A wrong edge-history register shows up as a count that is off by one. It appears two clock edges after the input toggles. A pulse counted twice, or a pulse dropped, shows at the end of a pulse burst. A wrong limit or a wrong wrap comparison shows as the wrong value on the first wrap. It is visible on `count` and on a flag in the cycle right after the wrapping edge. A fault in command ordering or in the clear path shows at once: `top` or `count` is wrong after the clock edge that follows the command, or without any edge for the asynchronous clear.

// File: rtl/tally_pkg.sv
package tally_pkg;

    typedef enum logic [1:0] {
        MODE_OFF  = 2'b00,
        MODE_SAMP = 2'b01,
        MODE_EXT  = 2'b10,
        MODE_QUAD = 2'b11
    } tally_mode_e;

    // one counting request per clock edge
    typedef struct packed {
        logic step;
        logic down;
    } step_req_t;

    typedef struct packed {
        logic hi_wrap;
        logic lo_wrap;
    } wrap_flags_t;

    localparam int HIST_DEPTH = 2;

    // picks whether a pulse is counted this edge, and in which direction
    function automatic step_req_t pick_step(tally_mode_e m, logic edge_hit,
                                            logic dir_bit, logic quad_dir);
        step_req_t r;
        r.step = 1'b0;
        r.down = dir_bit;
        case (m)
            MODE_SAMP: r.step = edge_hit;
            MODE_EXT:  r.step = 1'b1;
            MODE_QUAD: begin
                r.step = 1'b1;
                r.down = quad_dir;
            end
            default:   r.step = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/tally_edge_detect.sv
module tally_edge_detect
    import tally_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  tally_mode_e mode,
    input  logic        fall_edge,
    input  logic        count_down,
    input  logic        sig_a,
    input  logic        sig_b,
    output step_req_t   req
);

    logic [HIST_DEPTH-1:0] hist_q;
    logic                  edge_hit;

    always_ff @(posedge clk) begin
        if (rst) begin
            hist_q <= '0;
        end else begin
            hist_q <= {hist_q[HIST_DEPTH-2:0], sig_a};
        end
    end

    // hist_q[0] is the newest sample, hist_q[1] the one before
    always_comb begin
        if (fall_edge) begin
            edge_hit = !hist_q[0] && hist_q[1];
        end else begin
            edge_hit = hist_q[0] && !hist_q[1];
        end
    end

    assign req = pick_step(mode, edge_hit, count_down, sig_b);

    // R3: one sampled edge can never be counted on two consecutive clock edges
    p_single_count_r3: assert property (@(posedge clk) disable iff (rst)
        (mode == MODE_SAMP && req.step) |=>
        !(mode == MODE_SAMP && req.step && $stable(fall_edge)));

endmodule

// File: rtl/tally_top_reg.sv
module tally_top_reg #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold_clr,
    input  logic         buf_wr,
    input  logic [W-1:0] buf_din,
    input  logic         cmd_load_top,
    output logic [W-1:0] top_q
);

    localparam logic [W-1:0] TOP_INIT = {W{1'b1}};

    logic [W-1:0] buf_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            buf_q <= TOP_INIT;
        end else if (buf_wr) begin
            buf_q <= buf_din;
        end
    end

    always_ff @(posedge clk or posedge hold_clr) begin
        if (hold_clr) begin
            top_q <= TOP_INIT;
        end else if (rst) begin
            top_q <= TOP_INIT;
        end else if (cmd_load_top) begin
            top_q <= buf_q;
        end
    end

    // R9: the load command moves the staged value into the limit
    p_load_top_r9: assert property (@(posedge clk) disable iff (rst)
        cmd_load_top |=> (hold_clr || top_q == $past(buf_q)));

    // R9: a staging write alone leaves the limit untouched
    p_stage_only_r9: assert property (@(posedge clk) disable iff (rst)
        (buf_wr && !cmd_load_top && !hold_clr) |=> (hold_clr || $stable(top_q)));

    // R11: the clear forces the limit to its start value
    p_clear_top_r11: assert property (@(posedge clk) disable iff (rst)
        hold_clr |-> top_q == TOP_INIT);

endmodule

// File: rtl/tally_counter.sv
module tally_counter
    import tally_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold_clr,
    input  step_req_t    req,
    input  logic [W-1:0] top_q,
    input  logic         cmd_load_cnt,
    output logic [W-1:0] cnt_q,
    output wrap_flags_t  flags_q
);

    localparam logic [W-1:0] ZERO = '0;
    localparam logic [W-1:0] ONE  = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] cnt_d;
    wrap_flags_t  flags_d;

    always_comb begin
        cnt_d   = cnt_q;
        flags_d = '0;
        if (cmd_load_cnt) begin
            cnt_d = top_q;
        end else if (req.step) begin
            if (req.down) begin
                if (cnt_q == ZERO) begin
                    cnt_d           = top_q;
                    flags_d.lo_wrap = 1'b1;
                end else begin
                    cnt_d = cnt_q - ONE;
                end
            end else begin
                if (cnt_q == top_q) begin
                    cnt_d           = ZERO;
                    flags_d.hi_wrap = 1'b1;
                end else begin
                    cnt_d = cnt_q + ONE;
                end
            end
        end
    end

    always_ff @(posedge clk or posedge hold_clr) begin
        if (hold_clr) begin
            cnt_q   <= ZERO;
            flags_q <= '0;
        end else if (rst) begin
            cnt_q   <= ZERO;
            flags_q <= '0;
        end else begin
            cnt_q   <= cnt_d;
            flags_q <= flags_d;
        end
    end

    // R5: an overflow flag is only ever seen together with a zero count
    p_no_overflow_r5: assert property (@(posedge clk) disable iff (rst)
        flags_q.hi_wrap |-> cnt_q == ZERO);

    // R6: an underflow flag comes with the count reloaded from the limit
    p_underflow_reload_r6: assert property (@(posedge clk) disable iff (rst)
        flags_q.lo_wrap |-> cnt_q == $past(top_q));

    // R10: the load-count command lands the limit in the count
    p_load_cnt_r10: assert property (@(posedge clk) disable iff (rst)
        cmd_load_cnt |=> (hold_clr || cnt_q == $past(top_q)));

    // R11: the clear holds count and flags at zero
    p_clear_cnt_r11: assert property (@(posedge clk) disable iff (rst)
        hold_clr |-> (cnt_q == ZERO && flags_q == '0));

endmodule

// File: rtl/edge_tally_core.sv
module edge_tally_core
    import tally_pkg::*;
#(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         hold_clr,
    input  logic [1:0]   mode,
    input  logic         fall_edge,
    input  logic         count_down,
    input  logic         sig_a,
    input  logic         sig_b,
    input  logic         buf_wr,
    input  logic [W-1:0] buf_din,
    input  logic         cmd_load_top,
    input  logic         cmd_load_cnt,
    output logic [W-1:0] count,
    output logic [W-1:0] top,
    output logic         ovf,
    output logic         unf
);

    tally_mode_e  mode_e;
    step_req_t    req;
    logic [W-1:0] top_q;
    logic [W-1:0] cnt_q;
    wrap_flags_t  flags_q;

    assign mode_e = tally_mode_e'(mode);

    tally_edge_detect u_edge (
        .clk        (clk),
        .rst        (rst),
        .mode       (mode_e),
        .fall_edge  (fall_edge),
        .count_down (count_down),
        .sig_a      (sig_a),
        .sig_b      (sig_b),
        .req        (req)
    );

    tally_top_reg #(.W(W)) u_top (
        .clk          (clk),
        .rst          (rst),
        .hold_clr     (hold_clr),
        .buf_wr       (buf_wr),
        .buf_din      (buf_din),
        .cmd_load_top (cmd_load_top),
        .top_q        (top_q)
    );

    tally_counter #(.W(W)) u_cnt (
        .clk          (clk),
        .rst          (rst),
        .hold_clr     (hold_clr),
        .req          (req),
        .top_q        (top_q),
        .cmd_load_cnt (cmd_load_cnt),
        .cnt_q        (cnt_q),
        .flags_q      (flags_q)
    );

    assign count = cnt_q;
    assign top   = top_q;
    assign ovf   = flags_q.hi_wrap;
    assign unf   = flags_q.lo_wrap;

    // R2: in the off mode, with no load command, the count does not move
    p_off_holds_r2: assert property (@(posedge clk) disable iff (rst)
        (mode_e == MODE_OFF && !cmd_load_cnt && !hold_clr) |=>
        (hold_clr || $stable(count)));

endmodule

// File: tb/sim_edge_tally_core.sv
module sim_edge_tally_core;

    localparam int W = 8;

    logic         clk = 1'b0;
    logic         rst = 1'b1;
    logic         hold_clr = 1'b0;
    logic [1:0]   mode = 2'd0;
    logic         fall_edge = 1'b0;
    logic         count_down = 1'b0;
    logic         sig_a = 1'b0;
    logic         sig_b = 1'b0;
    logic         buf_wr = 1'b0;
    logic [W-1:0] buf_din = '0;
    logic         cmd_load_top = 1'b0;
    logic         cmd_load_cnt = 1'b0;
    logic [W-1:0] count;
    logic [W-1:0] top;
    logic         ovf;
    logic         unf;

    int checks = 0;
    int failures = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    edge_tally_core #(.W(W)) u0 (
        .clk(clk), .rst(rst), .hold_clr(hold_clr), .mode(mode),
        .fall_edge(fall_edge), .count_down(count_down), .sig_a(sig_a),
        .sig_b(sig_b), .buf_wr(buf_wr), .buf_din(buf_din),
        .cmd_load_top(cmd_load_top), .cmd_load_cnt(cmd_load_cnt),
        .count(count), .top(top), .ovf(ovf), .unf(unf)
    );

    typedef struct packed {
        logic [1:0] vmode;
        logic       vfall;
        logic       vdown;
        logic       vb;
        logic [7:0] pulses;
        logic [7:0] exp_cnt;
        logic [3:0] req;
    } vec_t;

    // limit is 0xFF and the count starts at 0 for every entry
    localparam vec_t VECS [8] = '{
        '{2'd1, 1'b0, 1'b0, 1'b0, 8'd5, 8'd5,   4'd3},  // R3 rising, up
        '{2'd1, 1'b1, 1'b0, 1'b0, 8'd3, 8'd3,   4'd3},  // R3 falling
        '{2'd1, 1'b0, 1'b1, 1'b0, 8'd2, 8'hFE,  4'd4},  // R4 down via wrap
        '{2'd0, 1'b0, 1'b0, 1'b0, 8'd4, 8'd0,   4'd2},  // R2 off ignores edges
        '{2'd2, 1'b0, 1'b0, 1'b0, 8'd7, 8'd7,   4'd7},  // R7 one per clock
        '{2'd2, 1'b0, 1'b1, 1'b0, 8'd3, 8'hFD,  4'd4},  // R4 external down
        '{2'd3, 1'b0, 1'b1, 1'b0, 8'd6, 8'd6,   4'd8},  // R8 b=0 up despite count_down
        '{2'd3, 1'b0, 1'b0, 1'b1, 8'd2, 8'hFE,  4'd8}   // R8 b=1 down
    };

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic clear_pulse();
        @(negedge clk) hold_clr = 1'b1;
        @(negedge clk) hold_clr = 1'b0;
    endtask

    initial begin
        #2_000_000;
        if (!finished) begin
            failures++;
            checks++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check(count == 8'd0, "R1 count after reset", count, 0);
        check(top == 8'hFF, "R1 limit after reset", top, 8'hFF);
        check(!ovf && !unf, "R1 flags after reset", {ovf, unf}, 0);

        foreach (VECS[i]) begin
            vec_t v = VECS[i];
            @(negedge clk);
            mode = 2'd0; sig_a = 1'b0;
            repeat (2) @(negedge clk);
            clear_pulse();
            mode = v.vmode; fall_edge = v.vfall; count_down = v.vdown; sig_b = v.vb;
            if (v.vmode == 2'd2 || v.vmode == 2'd3) begin
                for (int k = 0; k < int'(v.pulses); k++) @(negedge clk);
            end else begin
                for (int k = 0; k < int'(v.pulses); k++) begin
                    sig_a = 1'b1;
                    repeat (2) @(negedge clk);
                    sig_a = 1'b0;
                    repeat (2) @(negedge clk);
                end
            end
            mode = 2'd0;
            sig_b = 1'b0;
            @(negedge clk);
            check(count == v.exp_cnt, $sformatf("table entry %0d (R%0d)", i, v.req),
                  count, v.exp_cnt);
        end

        // R9 staging write leaves limit, load copies it
        clear_pulse();
        buf_din = 8'h05; buf_wr = 1'b1;
        @(negedge clk) buf_wr = 1'b0;
        @(negedge clk);
        check(top == 8'hFF, "R9 limit unchanged by staging write", top, 8'hFF);
        cmd_load_top = 1'b1;
        @(negedge clk) cmd_load_top = 1'b0;
        check(top == 8'h05, "R9 limit after load command", top, 5);

        // R10 load count from limit
        cmd_load_cnt = 1'b1;
        @(negedge clk) cmd_load_cnt = 1'b0;
        check(count == 8'h05, "R10 count after load command", count, 5);

        // R5 upward wrap at the limit
        mode = 2'd2; count_down = 1'b0;
        @(negedge clk);
        check(count == 8'd0, "R5 count wraps to zero", count, 0);
        check(ovf == 1'b1, "R5 overflow raised", ovf, 1);
        mode = 2'd0;
        @(negedge clk);
        check(ovf == 1'b0 && count == 8'd0, "R5 overflow lasts one cycle", {ovf, count}, 0);

        // R6 downward wrap at zero
        mode = 2'd2; count_down = 1'b1;
        @(negedge clk);
        check(count == 8'h05, "R6 count reloads limit", count, 5);
        check(unf == 1'b1, "R6 underflow raised", unf, 1);
        mode = 2'd0; count_down = 1'b0;
        @(negedge clk);
        check(unf == 1'b0 && count == 8'h05, "R6 underflow lasts one cycle", {unf, count}, 5);

        // R7 two clocks upward: 5 -> 0 -> 1
        mode = 2'd2;
        repeat (2) @(negedge clk);
        mode = 2'd0;
        check(count == 8'd1, "R7 two external pulses", count, 1);

        // R10 load-count beats a pulse and takes the old limit
        buf_din = 8'h09; buf_wr = 1'b1;
        @(negedge clk);
        buf_wr = 1'b0; mode = 2'd2; cmd_load_top = 1'b1; cmd_load_cnt = 1'b1;
        @(negedge clk);
        mode = 2'd0; cmd_load_top = 1'b0; cmd_load_cnt = 1'b0;
        check(count == 8'h05, "R10 count gets old limit over pulse", count, 5);
        check(top == 8'h09, "R9 limit loaded in same cycle", top, 9);

        // R11 asynchronous clear, held
        @(negedge clk);
        #2 hold_clr = 1'b1;
        #1;
        check(count == 8'd0 && top == 8'hFF, "R11 immediate clear", {count, top}, 8'hFF);
        mode = 2'd2; cmd_load_cnt = 1'b1; cmd_load_top = 1'b1;
        repeat (2) @(negedge clk);
        check(count == 8'd0 && top == 8'hFF, "R11 held through commands", {count, top}, 8'hFF);
        mode = 2'd0; cmd_load_cnt = 1'b0; cmd_load_top = 1'b0;
        @(negedge clk) hold_clr = 1'b0;
        @(negedge clk);
        check(count == 8'd0 && top == 8'hFF && !ovf && !unf, "R11 state after release",
              {count, top}, 8'hFF);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule